// File: doc/BRIEF.md
# Parallel Memory Device Bus Controller with Idle Power-Down

This block sits on the device side of a 16-bit parallel non-volatile memory and interprets the host's chip-enable, output-enable, write-enable and hardware-reset inputs. All four are active low. It enables the tri-state data drivers only during a read, and it issues read and write strobes to the core. It also keeps a flag that tells the core whether reads come from the storage array or from a separate identification register.

Power management uses two independent paths, and the low-power flag is registered. The first is deselection: either reset is held low, or the chip is deselected while reset is high. The second path needs no change on any control pin. The flag rises by itself when the 21-bit address has held one value for a parameterised number of clock edges. It drops again at the first edge that samples a different address. While the internal program/erase engine reports busy, the flag stays low whatever the chip-enable level or the address history.

Top module: `mbc_top`

## Requirements
- R1: `rd_stb` and `data_oe` are 1 in the same cycle exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `reset_n`=1. Otherwise both are 0.
- R2: `wr_stb` is 1 in the same cycle exactly when `ce_n`=0, `we_n`=0, `oe_n`=1 and `reset_n`=1. Otherwise it is 0.
- R3: When `oe_n`=1, `data_oe` is 0.
- R4: When `reset_n`=0 or `ce_n`=1, `data_oe` is 0, whatever the level of `oe_n`.
- R5: A clock edge that samples `reset_n`=0 sets `low_power` to 1. The first edge that samples `reset_n`=1 with `ce_n`=0 and a freshly changed address clears it to 0, with no extra recovery cycle.
- R6: An edge that samples `reset_n`=1, `ce_n`=1 and `busy`=0 sets `low_power` to 1.
- R7: An edge that samples `reset_n`=1 and `busy`=1 clears `low_power` to 0. This holds even with `ce_n`=1 or with a long-stable address.
- R8: With `IDLE_CYC`=N, let E be the edge that first samples a new address. If `addr` then stays unchanged, `low_power` becomes 1 at the Nth edge after E and is still 0 after edge N-1. Throughout this, `ce_n`=0 and `busy`=0.
- R9: Any change on any single `addr` bit, including bit 20, clears `low_power` to 0 at the edge that samples it, when `ce_n`=0 and `busy`=0.
- R10: An edge that samples `reset_n`=0 sets `mode_ident` to 0 (read-array mode).
- R11: An edge that samples `id_enter`=1 and `id_exit`=0 sets `mode_ident` to 1. It then holds at 1 over idle cycles until an exit or a reset.
- R12: An edge that samples `id_exit`=1 sets `mode_ident` to 0, even when `id_enter`=1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| reset_n | input | 1 | Hardware reset, active low, sampled synchronously |
| addr | input | 21 | Word address |
| busy | input | 1 | Internal program/erase engine active |
| id_enter | input | 1 | Command decoder accepted the identification sequence |
| id_exit | input | 1 | Command decoder saw a bad sequence or a return-to-array command |
| data_oe | output | 1 | Enable for the 16-bit tri-state data drivers |
| rd_stb | output | 1 | Read access strobe |
| wr_stb | output | 1 | Write access strobe |
| low_power | output | 1 | Device in a low-power state (registered) |
| mode_ident | output | 1 | 1 = identification register, 0 = storage array |

## Verification
The access decode (`data_oe`, `rd_stb`, `wr_stb`) is combinational, so the bench checks it one nanosecond after it drives the pins, before the next rising edge. `low_power` and `mode_ident` take one register stage, so they are sampled one nanosecond after the edge that captures the stimulus. The idle-power-down test counts edges from the edge that captures the new address. It samples after edge N-1 and after edge N, so an off-by-one in the stability counter shows up as a mismatch.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic {
      MODE_ARRAY = 1'b0,
      MODE_IDENT = 1'b1
   } op_mode_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic drive;
   } access_s;

endpackage

// File: rtl/mbc_access_decode.sv
module mbc_access_decode
   import mbc_pkg::*;
(
   input  logic    ce_n,
   input  logic    oe_n,
   input  logic    we_n,
   input  logic    reset_n,
   output access_s acc
);

   logic selected;

   always_comb begin
      selected  = reset_n & ~ce_n;
      acc.rd    = selected & ~oe_n & we_n;
      acc.wr    = selected & ~we_n & oe_n;
      acc.drive = acc.rd;
   end

endmodule

// File: rtl/mbc_idle_timer.sv
module mbc_idle_timer #(
   parameter int ADDR_W   = 21,
   parameter int IDLE_CYC = 8
) (
   input  logic              clk,
   input  logic              reset_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              addr_chg,
   output logic              idle_hit
);

   localparam int            CNT_W = $clog2(IDLE_CYC + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYC);

   if (IDLE_CYC < 1) begin : g_bad_limit
      $error("mbc_idle_timer: IDLE_CYC must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q, cnt_d;

   always_comb begin
      addr_chg = (addr != addr_q);
      if (addr_chg)
         cnt_d = '0;
      else if (cnt_q == LIMIT)
         cnt_d = cnt_q;
      else
         cnt_d = cnt_q + 1'b1;
      idle_hit = (cnt_d == LIMIT);
   end

   always_ff @(posedge clk) begin
      addr_q <= addr;
      if (!reset_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!reset_n)
      addr_chg |=> (cnt_q == '0))
      else $error("stability counter not cleared after address change");

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!reset_n)
      1'b1 |=> (cnt_q <= LIMIT))
      else $error("stability counter beyond limit");

endmodule

// File: rtl/mbc_power_ctrl.sv
module mbc_power_ctrl (
   input  logic clk,
   input  logic reset_n,
   input  logic ce_n,
   input  logic busy,
   input  logic idle_hit,
   output logic low_power
);

   logic lp_q;

   always_ff @(posedge clk) begin
      if (!reset_n)
         lp_q <= 1'b1;
      else
         lp_q <= ~busy & (ce_n | idle_hit);
   end

   assign low_power = lp_q;

   assert_busy_awake_R7: assert property (@(posedge clk) disable iff (!reset_n)
      busy |=> !low_power)
      else $error("low power while engine busy");

   assert_deselect_sleep_R6: assert property (@(posedge clk) disable iff (!reset_n)
      (ce_n && !busy) |=> low_power)
      else $error("deselected but not in low power");

endmodule

// File: rtl/mbc_mode_reg.sv
module mbc_mode_reg
   import mbc_pkg::*;
(
   input  logic clk,
   input  logic reset_n,
   input  logic id_enter,
   input  logic id_exit,
   output logic mode_ident
);

   op_mode_e mode_q;

   always_ff @(posedge clk) begin
      if (!reset_n)
         mode_q <= MODE_ARRAY;
      else if (id_exit)
         mode_q <= MODE_ARRAY;
      else if (id_enter)
         mode_q <= MODE_IDENT;
   end

   assign mode_ident = (mode_q == MODE_IDENT);

   assert_exit_wins_R12: assert property (@(posedge clk) disable iff (!reset_n)
      id_exit |=> !mode_ident)
      else $error("exit strobe did not restore array mode");

   assert_enter_ident_R11: assert property (@(posedge clk) disable iff (!reset_n)
      (id_enter && !id_exit) |=> mode_ident)
      else $error("enter strobe did not select identification");

   assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!reset_n)
      (!id_enter && !id_exit) |=> $stable(mode_ident))
      else $error("mode changed without strobe");

endmodule

// File: rtl/mbc_top.sv
module mbc_top
   import mbc_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int IDLE_CYC     = 8,
   parameter bit AUTO_STBY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              reset_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   input  logic              id_enter,
   input  logic              id_exit,
   output logic              data_oe,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic              low_power,
   output logic              mode_ident
);

   if (ADDR_W < 1) begin : g_bad_width
      $error("mbc_top: ADDR_W must be at least 1");
   end

   access_s acc;
   logic    addr_chg;
   logic    idle_hit;

   mbc_access_decode u_decode (
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .reset_n (reset_n),
      .acc     (acc)
   );

   if (AUTO_STBY_EN) begin : g_auto
      mbc_idle_timer #(
         .ADDR_W   (ADDR_W),
         .IDLE_CYC (IDLE_CYC)
      ) u_timer (
         .clk      (clk),
         .reset_n  (reset_n),
         .addr     (addr),
         .addr_chg (addr_chg),
         .idle_hit (idle_hit)
      );
   end else begin : g_no_auto
      assign addr_chg = 1'b0;
      assign idle_hit = 1'b0;
   end

   mbc_power_ctrl u_power (
      .clk       (clk),
      .reset_n   (reset_n),
      .ce_n      (ce_n),
      .busy      (busy),
      .idle_hit  (idle_hit),
      .low_power (low_power)
   );

   mbc_mode_reg u_mode (
      .clk        (clk),
      .reset_n    (reset_n),
      .id_enter   (id_enter),
      .id_exit    (id_exit),
      .mode_ident (mode_ident)
   );

   assign data_oe = acc.drive;
   assign rd_stb  = acc.rd;
   assign wr_stb  = acc.wr;

   assert_hiz_oe_R3: assert property (@(posedge clk) disable iff (!reset_n)
      oe_n |-> !data_oe)
      else $error("data driven with output enable high");

   assert_hiz_desel_R4: assert property (@(posedge clk) disable iff (!reset_n)
      ce_n |-> !data_oe)
      else $error("data driven while deselected");

   assert_rw_excl_R2: assert property (@(posedge clk) disable iff (!reset_n)
      wr_stb |-> (!rd_stb && !data_oe))
      else $error("write and read active together");

   assert_wake_on_addr_R9: assert property (@(posedge clk) disable iff (!reset_n)
      (addr_chg && !ce_n && !busy) |=> !low_power)
      else $error("address change did not leave low power");

endmodule

// File: tb/mbc_top_tb.sv
`timescale 1ns/100ps
module mbc_top_tb;

   localparam int AW   = 21;
   localparam int IDLE = 8;
   localparam int NVEC = 10;

   // {ce_n, oe_n, we_n, reset_n, busy, exp_oe, exp_rd, exp_wr, exp_lp}
   localparam logic [8:0] VEC [NVEC] = '{
      9'b0_0_1_1_0_1_1_0_0,   // R1 read
      9'b0_1_0_1_0_0_0_1_0,   // R2 write
      9'b0_1_1_1_0_0_0_0_0,   // R3 output disable
      9'b0_0_0_1_0_0_0_0_0,   // R1/R2 both low: neither
      9'b1_0_1_1_0_0_0_0_1,   // R4/R6 deselect
      9'b1_1_0_1_0_0_0_0_1,   // R6 deselect with write pins
      9'b1_0_1_1_1_0_0_0_0,   // R7 busy keeps awake
      9'b0_0_1_0_0_0_0_0_1,   // R4/R5 reset low
      9'b0_1_0_0_0_0_0_0_1,   // R2/R5 reset low blocks write
      9'b0_0_1_1_1_1_1_0_0    // R5/R7 back awake, busy
   };

   logic          clk = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reset_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          busy = 1'b0, id_enter = 1'b0, id_exit = 1'b0;
   logic          data_oe, rd_stb, wr_stb, low_power, mode_ident;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   mbc_top #(.ADDR_W(AW), .IDLE_CYC(IDLE), .AUTO_STBY_EN(1'b1)) u_dut (
      .clk(clk), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .reset_n(reset_n),
      .addr(addr), .busy(busy), .id_enter(id_enter), .id_exit(id_exit),
      .data_oe(data_oe), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .low_power(low_power), .mode_ident(mode_ident)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edge_wait();
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      // reset state
      @(negedge clk);
      reset_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
      edge_wait();
      edge_wait();
      chk("R5 reset low_power", low_power, 1'b1);
      chk("R10 reset mode", mode_ident, 1'b0);
      chk("R4 reset hiz", data_oe, 1'b0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {ce_n, oe_n, we_n, reset_n, busy} = VEC[i][8:4];
         addr = addr + 1'b1;
         #1;
         chk("R1 data_oe", data_oe, VEC[i][3]);
         chk("R1 rd_stb",  rd_stb,  VEC[i][2]);
         chk("R2 wr_stb",  wr_stb,  VEC[i][1]);
         edge_wait();
         chk("R5/R6/R7 low_power", low_power, VEC[i][0]);
      end

      // idle power-down: new address captured at edge E, then hold
      @(negedge clk);
      {ce_n, oe_n, we_n, reset_n, busy} = 5'b0_0_1_1_0;
      addr = 21'h0A5A5;
      edge_wait();
      chk("R9 change edge awake", low_power, 1'b0);
      for (int k = 1; k < IDLE; k++) edge_wait();
      chk("R8 awake after N-1", low_power, 1'b0);
      edge_wait();
      chk("R8 asleep after N", low_power, 1'b1);
      chk("R1 read still enabled", data_oe, 1'b1);
      edge_wait();
      chk("R8 stays asleep", low_power, 1'b1);

      // exit on top address bit
      @(negedge clk);
      addr[20] = ~addr[20];
      edge_wait();
      chk("R9 bit20 change wakes", low_power, 1'b0);
      for (int k = 0; k < IDLE; k++) edge_wait();
      chk("R8 asleep again", low_power, 1'b1);
      @(negedge clk);
      addr[0] = ~addr[0];
      edge_wait();
      chk("R9 bit0 change wakes", low_power, 1'b0);

      // busy overrides stable address and deselect
      @(negedge clk);
      busy = 1'b1; ce_n = 1'b1;
      for (int k = 0; k < IDLE + 4; k++) edge_wait();
      chk("R7 busy with stable addr and ce_n high", low_power, 1'b0);
      @(negedge clk);
      busy = 1'b0;
      edge_wait();
      chk("R6 sleep after busy ends", low_power, 1'b1);

      // reset release: awake on first edge with no wait
      @(negedge clk);
      ce_n = 1'b0; reset_n = 1'b0;
      edge_wait();
      chk("R5 reset low sleeps", low_power, 1'b1);
      @(negedge clk);
      reset_n = 1'b1; addr = addr + 21'd3;
      edge_wait();
      chk("R5 awake first edge after reset", low_power, 1'b0);

      // mode flag
      @(negedge clk);
      id_enter = 1'b1;
      edge_wait();
      chk("R11 enter ident", mode_ident, 1'b1);
      @(negedge clk);
      id_enter = 1'b0;
      edge_wait();
      edge_wait();
      chk("R11 ident holds", mode_ident, 1'b1);
      @(negedge clk);
      id_enter = 1'b1; id_exit = 1'b1;
      edge_wait();
      chk("R12 exit wins", mode_ident, 1'b0);
      @(negedge clk);
      id_exit = 1'b0;
      edge_wait();
      chk("R11 re-enter", mode_ident, 1'b1);
      @(negedge clk);
      id_enter = 1'b0; reset_n = 1'b0;
      edge_wait();
      chk("R10 reset clears ident", mode_ident, 1'b0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule